// File: doc/BRIEF.md
# CAN Receive Bit-Timing Sampler

This block turns an oversampled CAN receive line into one sampled bit per bit time. The line first passes through a two-flop synchronizer. While the block is idle it waits for a dominant (low) level. That moment becomes the timing anchor, and the block starts to emit a one-cycle `bit_valid` strobe with the sampled level on `bit_value` once per bit.

Timing is never free-running. The block keeps the anchor (the cycle of the most recent recessive-to-dominant edge) and the number of bits sampled since that edge. The next sample point is the anchor plus that many bit periods plus a fixed sample offset. Any falling edge while capturing moves the anchor. Stuff bits are ordinary bits here, so they take part in this resynchronisation.

A frame parser downstream drives three controls. One selects the fast data-phase rate, one returns to the nominal rate, and one ends the frame. Both rate requests re-anchor the timing. The two bit periods are given in clock cycles, so at a 50 MHz clock the usual 1 Mbit/s and 2 Mbit/s rates are 50 and 25 cycles. The sample point is a percentage, normally 70.

Top module: `canrx_bit_sampler`

## Requirements
- R1: After reset `bit_valid` is low, the block is idle, and the nominal rate is selected. With the line held high, no strobe appears.
- R2: In idle, let edge e be the first rising clock edge that samples `rx_line` low. The strobe for the first bit is high in the cycle that follows edge e+2+O, where O is the active sample offset.
- R3: The sample offset is floor(period × `sample_pct` / 100), with a floor of 1. Each rate has its own offset, computed from its own period.
- R4: If no falling edge and no request occurs, successive strobes are exactly one active period apart. Two strobes are never adjacent (periods of at least 2 are assumed).
- R5: While capturing, let edge e be the first rising edge that samples `rx_line` low after a high sample. The next strobe follows edge e+2+O. If a strobe is already due in the cycle right after edge e+2, that strobe is still emitted and the next one follows one period later.
- R6: `bit_value` during a strobe equals the `rx_line` level sampled by the rising edge two edges before the edge that raised the strobe.
- R7: If `fast_req` is sampled high by edge f while capturing, the fast rate becomes active. The next strobe follows edge f+Pf+Of, where Pf is the fast period and Of is the fast offset.
- R8: If `nom_req` (with `fast_req` low) is sampled high by edge f while capturing, the nominal rate becomes active. The next strobe follows edge f+Pn+On.
- R9: `frame_done` sampled high returns the block to idle with the nominal rate selected. No strobe follows until the line is sampled low again.
- R10: Priority, from highest to lowest: `frame_done`, then a rate request (fast wins over nominal), then a falling edge. Rate requests in idle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Asynchronous CAN receive line, low = dominant |
| nom_period | input | PERIOD_W | Nominal bit period in clock cycles |
| fast_period | input | PERIOD_W | Fast bit period in clock cycles |
| sample_pct | input | PCT_W | Sample point as a percentage of the bit period (1..100) |
| fast_req | input | 1 | Pulse: switch to the fast rate and re-anchor |
| nom_req | input | 1 | Pulse: switch back to the nominal rate and re-anchor |
| frame_done | input | 1 | Pulse: frame finished, return to idle |
| bit_valid | output | 1 | One-cycle strobe per sampled bit |
| bit_value | output | 1 | Sampled line level, valid with the strobe |

## Verification
A wrong anchor, a wrong count or a wrong rate select shows up on the ports as a strobe on the wrong clock cycle. The error appears at the very next sample point, so it is visible within one bit period. Missing re-anchoring on a falling edge only shows when the transmitter's bit length differs from the programmed period. For that reason the stimulus jitters the transmitted bit lengths, so every bit exercises resynchronisation. A stuck idle or capture state appears at once, either as strobes that continue after `frame_done` or as no strobe after a dominant start.

// File: rtl/canrx_pkg.sv
package canrx_pkg;

    // Divisor turning a percentage into a fraction of the period.
    localparam int unsigned PCT_SCALE = 100;

    // Index of each rate inside per-rate arrays.
    localparam int unsigned RATE_NOM  = 0;
    localparam int unsigned RATE_FAST = 1;
    localparam int unsigned NUM_RATES = 2;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_CAPTURE = 1'b1
    } sampler_state_e;

    // Synchronized view of the receive line.
    typedef struct packed {
        logic level;   // synchronized line level
        logic fall;    // recessive-to-dominant transition this cycle
    } rx_view_t;

    // Control requests arriving from the frame parser.
    typedef struct packed {
        logic done;
        logic go_fast;
        logic go_nom;
    } rate_ctrl_t;

endpackage

// File: rtl/canrx_sync_edge.sv
module canrx_sync_edge
    import canrx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     rx_in,
    output rx_view_t view
);
    logic meta_q;
    logic sync_q;
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            meta_q <= rx_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    always_comb begin
        view.level = sync_q;
        view.fall  = prev_q & ~sync_q;
    end
endmodule

// File: rtl/canrx_offset_calc.sv
module canrx_offset_calc
    import canrx_pkg::*;
#(
    parameter int unsigned PERIOD_W = 16,
    parameter int unsigned PCT_W    = 7
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [PERIOD_W-1:0] period,
    input  logic [PCT_W-1:0]    pct,
    output logic [PERIOD_W-1:0] offset
);
    localparam int unsigned PROD_W = PERIOD_W + PCT_W;

    logic [PROD_W-1:0] product;
    logic [PROD_W-1:0] quotient;

    always_comb begin
        product  = {{PCT_W{1'b0}}, period} * {{PERIOD_W{1'b0}}, pct};
        quotient = product / PROD_W'(PCT_SCALE);
    end

    // Registered so the divider stays off the sampling path.
    always_ff @(posedge clk) begin
        if (rst) begin
            offset <= PERIOD_W'(1);
        end else if (quotient == '0) begin
            offset <= PERIOD_W'(1);
        end else begin
            offset <= quotient[PERIOD_W-1:0];
        end
    end
endmodule

// File: rtl/canrx_bit_sched.sv
module canrx_bit_sched
    import canrx_pkg::*;
#(
    parameter int unsigned PERIOD_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  rx_view_t            view,
    input  rate_ctrl_t          ctrl,
    input  logic [PERIOD_W-1:0] nom_period,
    input  logic [PERIOD_W-1:0] fast_period,
    input  logic [PERIOD_W-1:0] nom_offset,
    input  logic [PERIOD_W-1:0] fast_offset,
    output logic                bit_valid,
    output logic                bit_value,
    output sampler_state_e      state,
    output logic                fast_active
);
    localparam int unsigned CNT_W = PERIOD_W + 1;

    sampler_state_e    state_q, state_d;
    logic              fast_q, fast_d;
    logic [CNT_W-1:0]  elapsed_q, elapsed_d;   // clocks since the anchor
    logic [CNT_W-1:0]  target_q, target_d;     // elapsed value of next sample
    logic              hit;
    logic [CNT_W-1:0]  cur_period, cur_offset;
    logic [CNT_W-1:0]  new_period, new_offset;
    logic              want_fast;

    always_comb begin
        cur_period = fast_q ? {1'b0, fast_period} : {1'b0, nom_period};
        cur_offset = fast_q ? {1'b0, fast_offset} : {1'b0, nom_offset};
        want_fast  = ctrl.go_fast;
        new_period = want_fast ? {1'b0, fast_period} : {1'b0, nom_period};
        new_offset = want_fast ? {1'b0, fast_offset} : {1'b0, nom_offset};
        hit        = (state_q == ST_CAPTURE) && (elapsed_q == target_q);
    end

    always_comb begin
        state_d   = state_q;
        fast_d    = fast_q;
        elapsed_d = elapsed_q + CNT_W'(1);
        target_d  = target_q;
        if (ctrl.done) begin
            state_d = ST_IDLE;
            fast_d  = 1'b0;
        end else if (state_q == ST_IDLE) begin
            if (!view.level) begin
                state_d   = ST_CAPTURE;
                elapsed_d = CNT_W'(1);
                target_d  = cur_offset;
            end
        end else if (ctrl.go_fast || ctrl.go_nom) begin
            fast_d    = want_fast;
            elapsed_d = CNT_W'(1);
            target_d  = new_period + new_offset;
        end else if (view.fall) begin
            elapsed_d = CNT_W'(1);
            target_d  = hit ? (cur_offset + cur_period) : cur_offset;
        end else if (hit) begin
            target_d  = target_q + cur_period;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            fast_q    <= 1'b0;
            elapsed_q <= '0;
            target_q  <= '0;
            bit_valid <= 1'b0;
            bit_value <= 1'b1;
        end else begin
            state_q   <= state_d;
            fast_q    <= fast_d;
            elapsed_q <= elapsed_d;
            target_q  <= target_d;
            bit_valid <= hit;
            bit_value <= view.level;
        end
    end

    assign state       = state_q;
    assign fast_active = fast_q;
endmodule

// File: rtl/canrx_bit_sampler.sv
module canrx_bit_sampler
    import canrx_pkg::*;
#(
    parameter int unsigned PERIOD_W = 16,
    parameter int unsigned PCT_W    = 7
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rx_line,
    input  logic [PERIOD_W-1:0] nom_period,
    input  logic [PERIOD_W-1:0] fast_period,
    input  logic [PCT_W-1:0]    sample_pct,
    input  logic                fast_req,
    input  logic                nom_req,
    input  logic                frame_done,
    output logic                bit_valid,
    output logic                bit_value
);
    rx_view_t            view;
    rate_ctrl_t          ctrl;
    logic [PERIOD_W-1:0] periods [NUM_RATES];
    logic [PERIOD_W-1:0] offsets [NUM_RATES];
    sampler_state_e      sched_state;
    logic                fast_active;

    assign periods[RATE_NOM]  = nom_period;
    assign periods[RATE_FAST] = fast_period;

    always_comb begin
        ctrl.done    = frame_done;
        ctrl.go_fast = fast_req;
        ctrl.go_nom  = nom_req;
    end

    canrx_sync_edge u_sync (
        .clk   (clk),
        .rst   (rst),
        .rx_in (rx_line),
        .view  (view)
    );

    for (genvar g = 0; g < NUM_RATES; g++) begin : g_rate
        canrx_offset_calc #(
            .PERIOD_W (PERIOD_W),
            .PCT_W    (PCT_W)
        ) u_off (
            .clk    (clk),
            .rst    (rst),
            .period (periods[g]),
            .pct    (sample_pct),
            .offset (offsets[g])
        );
    end

    canrx_bit_sched #(
        .PERIOD_W (PERIOD_W)
    ) u_sched (
        .clk         (clk),
        .rst         (rst),
        .view        (view),
        .ctrl        (ctrl),
        .nom_period  (nom_period),
        .fast_period (fast_period),
        .nom_offset  (offsets[RATE_NOM]),
        .fast_offset (offsets[RATE_FAST]),
        .bit_valid   (bit_valid),
        .bit_value   (bit_value),
        .state       (sched_state),
        .fast_active (fast_active)
    );
endmodule

// File: rtl/canrx_bit_sampler_chk.sv
module canrx_bit_sampler_chk
    import canrx_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           rx_line,
    input logic           fast_req,
    input logic           nom_req,
    input logic           frame_done,
    input logic           bit_valid,
    input logic           bit_value,
    input sampler_state_e sched_state,
    input logic           fast_active
);
    AST_STROBE_NEEDS_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        bit_valid |-> $past(sched_state) == ST_CAPTURE) else $error("strobe outside capture"); // R2

    AST_NO_ADJACENT_STROBE: assert property (@(posedge clk) disable iff (rst)
        bit_valid |=> !bit_valid) else $error("adjacent strobes"); // R4

    AST_VALUE_FROM_LINE: assert property (@(posedge clk) disable iff (rst)
        bit_valid |-> bit_value == $past(rx_line, 3)) else $error("value not from line"); // R6

    AST_FAST_SELECTED: assert property (@(posedge clk) disable iff (rst)
        (sched_state == ST_CAPTURE && fast_req && !frame_done) |=> fast_active) else $error("fast not taken"); // R7

    AST_NOM_SELECTED: assert property (@(posedge clk) disable iff (rst)
        (sched_state == ST_CAPTURE && nom_req && !fast_req && !frame_done) |=> !fast_active) else $error("nominal not taken"); // R8

    AST_DONE_IDLES: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> (sched_state == ST_IDLE && !fast_active)) else $error("done ignored"); // R9

    AST_IDLE_NO_FAST: assert property (@(posedge clk) disable iff (rst)
        (sched_state == ST_IDLE && !fast_active) |=> !fast_active) else $error("rate changed in idle"); // R10
endmodule

bind canrx_bit_sampler canrx_bit_sampler_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .rx_line     (rx_line),
    .fast_req    (fast_req),
    .nom_req     (nom_req),
    .frame_done  (frame_done),
    .bit_valid   (bit_valid),
    .bit_value   (bit_value),
    .sched_state (sched_state),
    .fast_active (fast_active)
);

// File: tb/canrx_bit_sampler_tb_top.sv
module canrx_bit_sampler_tb_top;
    localparam int PW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rx = 1'b1;
    logic [PW-1:0] nom_p = 16'd50;
    logic [PW-1:0] fast_p = 16'd25;
    logic [6:0]    pct = 7'd70;
    logic          fast_req = 1'b0, nom_req = 1'b0, frame_done = 1'b0;
    logic          bit_valid, bit_value;

    int checks = 0, errors = 0;
    int cyc = 0;
    logic hist [16];

    // bench reference model state
    bit    m_cap = 0, m_fast = 0;
    int    exp_next = 0;
    bit    exp_pend = 0, exp_val = 1;
    string cause = "R1", pend_cause = "R1";

    always #10 clk = ~clk;

    canrx_bit_sampler #(.PERIOD_W(PW), .PCT_W(7)) dut_i (
        .clk(clk), .rst(rst), .rx_line(rx),
        .nom_period(nom_p), .fast_period(fast_p), .sample_pct(pct),
        .fast_req(fast_req), .nom_req(nom_req), .frame_done(frame_done),
        .bit_valid(bit_valid), .bit_value(bit_value)
    );

    function automatic int off_of(int p, int q);
        int o = (p * q) / 100;
        return (o < 1) ? 1 : o;
    endfunction

    function automatic int per_sel(bit f);
        return f ? int'(fast_p) : int'(nom_p);
    endfunction

    function automatic int off_sel(bit f);
        return off_of(per_sel(f), int'(pct));
    endfunction

    initial for (int i = 0; i < 16; i++) hist[i] = 1'b1;

    // Reference model: processes the cycle that ends at this edge.
    always @(posedge clk) begin
        int  c;
        bit  hit, lvl, lvl_prev;
        c        = cyc;
        lvl      = hist[(c - 1) & 15];
        lvl_prev = hist[(c - 2) & 15];
        if (rst) begin
            m_cap = 0; m_fast = 0; exp_pend = 0; cause = "R1";
        end else begin
            hit = m_cap && (c + 1 == exp_next);
            exp_pend = hit;
            exp_val = lvl;
            pend_cause = hit ? cause : (m_cap ? cause : "R9");
            if (frame_done) begin
                m_cap = 0; m_fast = 0; cause = "R9 R10";
            end else if (!m_cap) begin
                if (!lvl) begin
                    m_cap = 1; exp_next = c + 1 + off_sel(m_fast); cause = "R2 R3";
                end
            end else if (fast_req || nom_req) begin
                m_fast = fast_req;
                exp_next = c + 1 + per_sel(m_fast) + off_sel(m_fast);
                cause = fast_req ? "R7 R3" : "R8";
            end else if (lvl_prev && !lvl) begin
                exp_next = hit ? c + 1 + off_sel(m_fast) + per_sel(m_fast)
                               : c + 1 + off_sel(m_fast);
                cause = "R5";
            end else if (hit) begin
                exp_next = exp_next + per_sel(m_fast);
                cause = "R4";
            end
        end
        cyc = c + 1;
        hist[cyc & 15] = rx;
    end

    // Output comparison away from the active edge.
    always @(negedge clk) begin
        if (!rst && (bit_valid || exp_pend)) begin
            checks++;
            if (bit_valid !== exp_pend || (exp_pend && bit_value !== exp_val)) begin
                errors++;
                $display("FAIL %s cyc %0d: valid/value actual %b/%b expected %b/%b",
                         pend_cause, cyc, bit_valid, bit_value, exp_pend, exp_val);
            end
        end
    end

    task automatic hold(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(int which);
        @(negedge clk);
        if (which == 0) fast_req = 1'b1;
        else if (which == 1) nom_req = 1'b1;
        else frame_done = 1'b1;
        @(negedge clk);
        fast_req = 1'b0; nom_req = 1'b0; frame_done = 1'b0;
    endtask

    // Random bits, each jittered around the given period.
    task automatic send_bits(int n, int p, bit first_low);
        for (int i = 0; i < n; i++) begin
            int j;
            @(negedge clk);
            rx = (i == 0 && first_low) ? 1'b0 : 1'(($urandom % 2));
            j = p + int'($urandom % 5) - 2;
            hold(j - 1);
        end
    endtask

    task automatic frame(bit use_fast);
        send_bits(12 + int'($urandom % 20), int'(nom_p), 1'b1);
        if (use_fast) begin
            pulse(0);
            send_bits(10 + int'($urandom % 30), int'(fast_p), 1'b0);
            pulse(1);
        end
        send_bits(5 + int'($urandom % 6), int'(nom_p), 1'b0);
        @(negedge clk); rx = 1'b1;
        hold(200);
        pulse(2);
        hold(300);   // idle: no strobes (R9)
    endtask

    task automatic check_quiet(string tag);
        checks++;
        if (bit_valid !== 1'b0) begin
            errors++;
            $display("FAIL %s: bit_valid actual %b expected 0", tag, bit_valid);
        end
    endtask

    initial begin
        void'($urandom(32'h5eed_c0de));
        hold(5);
        check_quiet("R1");
        @(negedge clk) rst = 1'b0;
        hold(100);
        check_quiet("R1");
        // rate requests in idle are ignored (R10)
        pulse(0);
        hold(50);
        check_quiet("R10");
        for (int k = 0; k < 6; k++) frame(k % 2 == 1);
        // offset floor of one (R3)
        pct = 7'd1; hold(10);
        for (int k = 0; k < 2; k++) frame(1'b1);
        // odd period with fractional offset (R3)
        pct = 7'd60; nom_p = 16'd37; fast_p = 16'd13; hold(10);
        for (int k = 0; k < 3; k++) frame(1'b1);
        // done together with a fast request mid-frame (R10)
        pct = 7'd70; nom_p = 16'd50; fast_p = 16'd25; hold(10);
        send_bits(8, 50, 1'b1);
        @(negedge clk); rx = 1'b1; fast_req = 1'b1; frame_done = 1'b1;
        @(negedge clk); fast_req = 1'b0; frame_done = 1'b0;
        hold(300);
        check_quiet("R10");
        frame(1'b0);   // nominal rate restored after done (R9)
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog R1..: run did not finish, actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule